// File: doc/BRIEF.md
# Sticky Alert and Live Status Register Block

This block keeps two status views built from one set of fault inputs. The live view shows each fault input as it is at the moment of the read and holds nothing, with one exception: a conversion-ready flag that stays set until the matching result is read. The alert view catches every fault event and keeps it until software writes a 1 to that bit. Two further alert bits record that a reset took place and that a register write arrived too early, while the calibration refresh after reset was still running. An active-low alert pin is driven from the alert bits that a software mask enables.

Software reaches the block through a simple strobe port with registered read data. There are four word addresses: live (0), alert (1), mask (2) and command (3). A write of the reset key to the command address resets the block in exactly the way the reset pin does.

Top module: `stat_regs_top`

## Requirements
- R1: Live bits [N_FAULT-1:0] at address 0 return the fault inputs as sampled at the read edge, and they do not latch. A fault that has already gone away reads 0.
- R2: Live bit N_FAULT (conversion ready) is set by a pulse on adc_done_i and holds over any number of reads. It clears on result_rd_i. If both arrive in the same cycle, the bit stays set.
- R3: Alert bits [N_FAULT-1:0] at address 1 set on any cycle in which their fault input is high. Each bit clears only when a 1 is written to it. Writing 0 to a bit leaves it unchanged.
- R4: If an event and a write-1-to-clear hit the same alert bit in the same cycle, the bit stays set.
- R5: Alert bit N_FAULT+1 (reset occurred) is 1 after every reset, hardware or software.
- R6: Writing CMD_KEY to address 3 resets the block to the same state as the reset pin. That state is: alert holds only the reset bit, the mask is all ones, the ready flag is 0, and the calibration window restarts. Writing any other value to address 3 has no effect.
- R7: For CAL_CYCLES cycles after any reset, every write is dropped and sets alert bit N_FAULT (calibration access error).
- R8: alert_n_o is low exactly when an alert bit is 1 and its mask bit is also 1. The mask at address 2 resets to all ones, N_FAULT+2 bits wide, so the pin is low right after reset.
- R9: rvalid_o pulses one cycle after rd_en_i, carrying the addressed register zero-extended to DW bits. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | N_FAULT | Instantaneous fault conditions |
| adc_done_i | input | 1 | Conversion complete pulse |
| result_rd_i | input | 1 | Conversion result has been read |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, registered |
| rvalid_o | output | 1 | Read data valid |
| alert_n_o | output | 1 | Active-low alert |

## Verification
The bench targets the cases where the read-only and sticky views differ. It reads a fault that has already gone away; a design that latched the live bits would still return it. It writes zeros to the alert register, and it clears a bit while its event is still active. A design with the wrong priority would lose that event. The bench also writes during the calibration window, both after the reset pin and after the software key; a design that accepted those writes would change the mask and fail to flag the error. It compares the state left by the key against the state after reset, because any difference from the pin reset shows up as a different mask, ready flag or alert value.

// File: rtl/stat_pkg.sv
`timescale 1ns/1ps
package stat_pkg;
  typedef enum logic [1:0] {
    RA_LIVE  = 2'd0,
    RA_ALERT = 2'd1,
    RA_MASK  = 2'd2,
    RA_CMD   = 2'd3
  } reg_addr_e;

  // next value of a sticky bit: an event beats a clear
  function automatic logic sticky_next(logic cur, logic ev, logic clr);
    return ev | (cur & ~clr);
  endfunction
endpackage

// File: rtl/sticky_bank.sv
`timescale 1ns/1ps
module sticky_bank #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  import stat_pkg::*;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o[b] <= RST_VAL[b];
      else if (srst_i) q_o[b] <= RST_VAL[b];
      else             q_o[b] <= sticky_next(q_o[b], set_i[b], clr_i[b]);
    end

    // R3: a set bit survives anything except a 1-write or a reset
    a_r3_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o[b] && !clr_i[b] && !srst_i) |=> q_o[b]);
    // R4: an event sets the bit even when a clear lands with it
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i[b] && !srst_i) |=> q_o[b]);
  end
endmodule

// File: rtl/cal_guard.sv
`timescale 1ns/1ps
module cal_guard #(
  parameter int unsigned CAL_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srst_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(CAL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CAL_CYCLES);

  logic [CW-1:0] cnt_q;

  assign busy_o = (cnt_q != LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (srst_i) cnt_q <= '0;
    else if (busy_o) cnt_q <= cnt_q + 1'b1;
  end

  // R7: the window reopens after a software reset
  a_r7_window_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    srst_i |=> busy_o);
endmodule

// File: rtl/drdy_flag.sv
`timescale 1ns/1ps
module drdy_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic srst_i,
  input  logic done_i,
  input  logic take_i,
  output logic q_o
);
  import stat_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (srst_i) q_o <= 1'b0;
    else             q_o <= sticky_next(q_o, done_i, take_i);
  end

  // R2: completion sets the flag, and only a result read drops it
  a_r2_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !srst_i) |=> q_o);
  a_r2_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !take_i && !srst_i) |=> q_o);
endmodule

// File: rtl/stat_regs_top.sv
`timescale 1ns/1ps
module stat_regs_top #(
  parameter int unsigned N_FAULT    = 6,
  parameter int unsigned DW         = 16,
  parameter int unsigned CAL_CYCLES = 2000,
  parameter logic [15:0] CMD_KEY    = 16'h5AC3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FAULT-1:0] fault_i,
  input  logic               adc_done_i,
  input  logic               result_rd_i,
  input  logic               rd_en_i,
  input  logic               wr_en_i,
  input  logic [1:0]         addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic               rvalid_o,
  output logic               alert_n_o
);
  import stat_pkg::*;

  localparam int unsigned AW      = N_FAULT + 2;
  localparam int unsigned CAL_BIT = N_FAULT;
  localparam int unsigned RST_BIT = N_FAULT + 1;
  localparam logic [AW-1:0] ALERT_RST = AW'(1) << RST_BIT;

  // named internal events
  logic          cal_busy;
  logic          sw_rst_q;
  logic          wr_ok;
  logic          cmd_hit;
  logic          early_wr;
  logic          drdy;
  logic [AW-1:0] alert_q, alert_set, alert_clr, mask_q;
  logic [N_FAULT:0] live_vec;
  logic [DW-1:0] rd_mux;

  assign wr_ok    = wr_en_i && !cal_busy && !sw_rst_q;
  assign early_wr = wr_en_i && cal_busy;
  assign cmd_hit  = wr_ok && (addr_i == RA_CMD) && (wdata_i[15:0] == CMD_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_rst_q <= 1'b0;
    else        sw_rst_q <= cmd_hit;
  end

  cal_guard #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
    .clk(clk), .rst_n(rst_n), .srst_i(sw_rst_q), .busy_o(cal_busy)
  );

  drdy_flag u_drdy (
    .clk(clk), .rst_n(rst_n), .srst_i(sw_rst_q),
    .done_i(adc_done_i), .take_i(result_rd_i), .q_o(drdy)
  );

  always_comb begin
    alert_set          = '0;
    alert_set[N_FAULT-1:0] = fault_i;
    alert_set[CAL_BIT] = early_wr;
    alert_clr = (wr_ok && addr_i == RA_ALERT) ? wdata_i[AW-1:0] : '0;
  end

  sticky_bank #(.W(AW), .RST_VAL(ALERT_RST)) u_alert (
    .clk(clk), .rst_n(rst_n), .srst_i(sw_rst_q),
    .set_i(alert_set), .clr_i(alert_clr), .q_o(alert_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            mask_q <= '1;
    else if (sw_rst_q)                     mask_q <= '1;
    else if (wr_ok && addr_i == RA_MASK)   mask_q <= wdata_i[AW-1:0];
  end

  assign live_vec  = {drdy, fault_i};
  assign alert_n_o = ~|(alert_q & mask_q);

  always_comb begin
    rd_mux = '0;
    case (reg_addr_e'(addr_i))
      RA_LIVE:  rd_mux[N_FAULT:0] = live_vec;
      RA_ALERT: rd_mux[AW-1:0]    = alert_q;
      RA_MASK:  rd_mux[AW-1:0]    = mask_q;
      default:  rd_mux            = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rd_mux;
    end
  end

  // R5: a software reset leaves the reset flag set and the mask open
  a_r5_flag_after_swrst: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_q |=> (alert_q[RST_BIT] && mask_q == '1));
  // R7: a write inside the window raises the calibration error
  a_r7_early_write_flag: assert property (@(posedge clk) disable iff (!rst_n)
    early_wr |=> alert_q[CAL_BIT]);
  // R8: with nothing pending the pin stays high
  a_r8_quiet_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_q == '0) |-> alert_n_o);
endmodule

// File: tb/stat_regs_top_test.sv
`timescale 1ns/1ps
module stat_regs_top_test;
  localparam int NF  = 6;
  localparam int DW  = 16;
  localparam int CAL = 32;
  localparam logic [15:0] KEY = 16'h5AC3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NF-1:0] fault = '0;
  logic adc_done = 0, result_rd = 0, rd_en = 0, wr_en = 0;
  logic [1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rvalid, alert_n;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  stat_regs_top #(.N_FAULT(NF), .DW(DW), .CAL_CYCLES(CAL), .CMD_KEY(KEY)) uut (
    .clk(clk), .rst_n(rst_n), .fault_i(fault), .adc_done_i(adc_done),
    .result_rd_i(result_rd), .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .alert_n_o(alert_n)
  );

  // monitor: pop one expectation per returned read
  always @(negedge clk) begin
    if (rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected read data: actual %h expected none", rdata);
      end else begin
        automatic logic [DW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s read: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [DW-1:0] e, input string t);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_pin(input logic e, input string t);
    checks++;
    if (alert_n !== e) begin
      errors++;
      $display("FAIL %s alert_n: actual %b expected %b", t, alert_n, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R5 R8: reset flag drives the pin at once
    chk_pin(1'b0, "R5");
    rd(2'd1, 16'h0080, "R5");
    rd(2'd2, 16'h00FF, "R8");
    rd(2'd0, 16'h0000, "R1");
    // R7: write inside the window is dropped and flagged
    wr(2'd2, 16'h0000);
    rd(2'd1, 16'h00C0, "R7");
    rd(2'd2, 16'h00FF, "R7");
    repeat (CAL + 4) @(negedge clk);
    wr(2'd1, 16'h00C0);
    rd(2'd1, 16'h0000, "R3");
    chk_pin(1'b1, "R8");
    // R1 R3: pulsed fault gone from live, kept in alert
    @(negedge clk); fault[2] = 1'b1;
    @(negedge clk); fault[2] = 1'b0;
    rd(2'd0, 16'h0000, "R1");
    rd(2'd1, 16'h0004, "R3");
    fault[0] = 1'b1;
    rd(2'd0, 16'h0001, "R1");
    fault[0] = 1'b0;
    wr(2'd1, 16'h0000);
    rd(2'd1, 16'h0005, "R3");
    wr(2'd1, 16'h0004);
    rd(2'd1, 16'h0001, "R3");
    // R4: clear while the event is active
    fault[0] = 1'b1;
    wr(2'd1, 16'h0001);
    fault[0] = 1'b0;
    rd(2'd1, 16'h0001, "R4");
    wr(2'd1, 16'h0001);
    rd(2'd1, 16'h0000, "R4");
    // R8: mask gating
    wr(2'd2, 16'h0001);
    @(negedge clk); fault[3] = 1'b1;
    @(negedge clk); fault[3] = 1'b0;
    rd(2'd1, 16'h0008, "R8");
    chk_pin(1'b1, "R8");
    wr(2'd2, 16'h0008);
    chk_pin(1'b0, "R8");
    wr(2'd1, 16'h0008);
    chk_pin(1'b1, "R8");
    rd(2'd2, 16'h0008, "R8");
    // R2: ready flag
    @(negedge clk); adc_done = 1'b1;
    @(negedge clk); adc_done = 1'b0;
    rd(2'd0, 16'h0040, "R2");
    rd(2'd0, 16'h0040, "R2");
    @(negedge clk); result_rd = 1'b1;
    @(negedge clk); result_rd = 1'b0;
    rd(2'd0, 16'h0000, "R2");
    @(negedge clk); adc_done = 1'b1; result_rd = 1'b1;
    @(negedge clk); adc_done = 1'b0; result_rd = 1'b0;
    rd(2'd0, 16'h0040, "R2");
    // R6: wrong key does nothing, right key resets
    wr(2'd3, 16'h1234);
    rd(2'd1, 16'h0000, "R6");
    rd(2'd2, 16'h0008, "R6");
    rd(2'd0, 16'h0040, "R6");
    wr(2'd3, KEY);
    repeat (2) @(negedge clk);
    chk_pin(1'b0, "R6");
    rd(2'd1, 16'h0080, "R6");
    rd(2'd2, 16'h00FF, "R6");
    rd(2'd0, 16'h0000, "R6");
    wr(2'd2, 16'h0000);
    rd(2'd2, 16'h00FF, "R7");
    rd(2'd1, 16'h00C0, "R7");
    // R9: command address reads zero
    rd(2'd3, 16'h0000, "R9");
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 missing reads: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule